// File: doc/BRIEF.md
# Programmer Erase and Program Sequencer

This block sits inside a device programmer and walks a one-time-style electrically erasable ROM through its two bulk algorithms. It drives the ROM's address, write data and the active-low chip, output and write strobes, plus two flags that switch the high-voltage supplies onto the output-enable pin and onto the address line that selects chip erase. The erase algorithm lifts both high voltages, holds a long write pulse, drops the supplies, waits out a recovery time and then reads the whole array, expecting every byte to be blank (all ones). The program algorithm lifts the output-enable high voltage and, for each address in ascending order, fetches one byte from a source buffer, sets it up on the data pins and applies a fixed-width write pulse. After the last byte and a recovery time it reads the array back and compares it, again from address zero, against a second pass of the same source.

A start pulse with a two-bit mode selects erase, program, or erase followed by program. Busy is raised for the whole run and drops after a one-cycle done pulse that carries the pass flag and, on failure, the first address that did not compare. Every pulse width, set-up and hold interval, recovery wait and read access wait is a cycle count set by a parameter.

The source buffer is a valid/ready stream. The sequencer raises `src_ready` with the wanted address on `src_addr` and keeps both steady until a cycle in which `src_valid` is also high; that cycle transfers `src_data`. The source may hold `src_valid` low for any number of cycles and the sequencer simply waits. `src_valid` without `src_ready` transfers nothing.

Top module: `prom_burn_seq`

## Requirements
- R1: Out of reset and whenever idle, busy and done are low, all three strobes are high, both high-voltage flags are low and `src_ready` is low.
- R2: A start pulse while idle begins a run with mode 2'b01 = erase, 2'b10 = program, 2'b11 = erase then program; mode 2'b00 starts nothing, and a start pulse during a run is ignored.
- R3: The erase write pulse holds `dev_we_n` low for exactly ERASE_CYC cycles while `hv_a9`, `hv_oe` are high and `dev_ce_n` is low, with both flags and chip enable set at least SETUP_CYC cycles before the pulse.
- R4: After the erase pulse the supplies are dropped and no read (chip and output enable both low) starts until SETUP_CYC + REC_CYC cycles after `dev_we_n` rises; no read ever occurs with a high-voltage flag set.
- R5: Erase verification reads addresses 0 to the last in ascending order and fails on the first byte that is not all ones.
- R6: Programming writes each address from 0 to the last exactly once, in ascending order, with the byte the source delivered for that address, using a `dev_we_n` low pulse of exactly PROG_CYC cycles while `hv_oe` is high, `hv_a9` low and `dev_ce_n` low.
- R7: `dev_addr` and `dev_wdata` do not change in the cycle `dev_we_n` falls, during the pulse, or in the cycle it rises.
- R8: After the last write, the output-enable supply is dropped and at least SETUP_CYC + REC_CYC cycles pass before the first verify read; verification reads addresses 0 upward and compares each with a fresh source byte for that address.
- R9: The first miscompare ends verification at once: done is raised with pass low and `fail_addr` equal to that address, and no further address is read.
- R10: Busy is high from the cycle after an accepted start through the done cycle; done is high for exactly one cycle, and pass and `fail_addr` keep their values until the next run ends.
- R11: While `src_ready` is high and `src_valid` low, `src_ready` stays high and `src_addr` does not change; an address is consumed only by a cycle with both high.
- R12: In mode 2'b11 a failed erase verification ends the run without any program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled while idle |
| mode | input | 2 | Run selection: 01 erase, 10 program, 11 erase then program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run, valid with done |
| fail_addr | output | AW | First miscomparing address of the last run |
| src_addr | output | AW | Address of the byte wanted from the source |
| src_ready | output | 1 | Sequencer accepts a source byte |
| src_valid | input | 1 | Source byte present |
| src_data | input | DW | Source byte |
| dev_addr | output | AW | ROM address |
| dev_wdata | output | DW | ROM write data |
| dev_wdata_oe | output | 1 | Drive `dev_wdata` onto the ROM data pins |
| dev_rdata | input | DW | ROM read data |
| dev_ce_n | output | 1 | ROM chip enable, active low |
| dev_oe_n | output | 1 | ROM output enable logic level, active low |
| dev_we_n | output | 1 | ROM write strobe, active low |
| hv_oe | output | 1 | Switch the high voltage onto the output-enable pin |
| hv_a9 | output | 1 | Switch the high voltage onto the erase-select address pin |

## Verification
The bench targets a stalling source, an erase that leaves one weak bit, a reprogram over unerased contents that can only fail at one interior address, an erase-then-program run whose erase fails, and start pulses that arrive during a run or with mode 00. A design that mishandled back-pressure would write one address with another's byte or skip an address; one that did not abort on the first miscompare would report a later address or keep reading; one that ignored the erase result would go on to program a bad array. A short recovery or a read under high voltage would show as a read starting too few cycles after the last write pulse, and a wrong pulse count as a low pulse of the wrong width.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_BOTH  = 2'b11
  } burn_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_ARM,
    ST_E_PULSE,
    ST_E_REL,
    ST_E_REC,
    ST_P_FETCH,
    ST_P_SETUP,
    ST_P_PULSE,
    ST_P_HOLD,
    ST_P_REC,
    ST_V_FETCH,
    ST_V_READ,
    ST_V_CMP,
    ST_DONE
  } burn_state_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_burn_timer.sv
module prom_burn_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          hit
);
  logic [CW-1:0] cnt_q;

  assign hit = run && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || hit) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/prom_burn_addr.sv
module prom_burn_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) addr_q <= '0;
    else if (inc)      addr_q <= addr_q + AW'(1);
  end

  assign addr = addr_q;
  assign last = &addr_q;
endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
  import prom_burn_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int ERASE_CYC = 20_000_000,
  parameter int PROG_CYC  = 4000,
  parameter int REC_CYC   = 200,
  parameter int RD_WAIT   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic [AW-1:0] src_addr,
  output logic          src_ready,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_wdata_oe,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_ce_n,
  output logic          dev_oe_n,
  output logic          dev_we_n,
  output logic          hv_oe,
  output logic          hv_a9
);
  localparam int MAXC = max_i(max_i(max_i(SETUP_CYC, ERASE_CYC), max_i(PROG_CYC, REC_CYC)), RD_WAIT);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [DW-1:0] BLANK = {DW{1'b1}};

  burn_state_e state_q, state_d;
  burn_mode_e  mode_e;
  logic          prog_after_q, vfy_prog_q;
  logic [DW-1:0] data_q, rd_q, expect_b;
  logic          pass_q;
  logic [AW-1:0] fail_addr_q;
  logic          run, hit;
  logic [CW-1:0] lim;
  logic          addr_clr, addr_inc, last;
  logic [AW-1:0] addr;
  logic          ld_src, ld_rd, fin, fin_ok;

  assign mode_e = burn_mode_e'(mode);

  prom_burn_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .lim(lim), .hit(hit)
  );

  prom_burn_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
    .addr(addr), .last(last)
  );

  // interval length of each timed state
  always_comb begin
    run = 1'b1;
    lim = '1;
    case (state_q)
      ST_E_ARM, ST_E_REL, ST_P_SETUP, ST_P_HOLD: lim = CW'(SETUP_CYC);
      ST_E_PULSE:                                lim = CW'(ERASE_CYC);
      ST_P_PULSE:                                lim = CW'(PROG_CYC);
      ST_E_REC, ST_P_REC:                        lim = CW'(REC_CYC);
      ST_V_READ:                                 lim = CW'(RD_WAIT);
      default:                                   run = 1'b0;
    endcase
  end

  assign expect_b = vfy_prog_q ? data_q : BLANK;

  always_comb begin
    state_d  = state_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    ld_src   = 1'b0;
    ld_rd    = 1'b0;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    case (state_q)
      ST_IDLE: if (start && mode_e != MODE_NONE) begin
        addr_clr = 1'b1;
        state_d  = mode[0] ? ST_E_ARM : ST_P_FETCH;
      end
      ST_E_ARM:   if (hit) state_d = ST_E_PULSE;
      ST_E_PULSE: if (hit) state_d = ST_E_REL;
      ST_E_REL:   if (hit) state_d = ST_E_REC;
      ST_E_REC:   if (hit) begin
        addr_clr = 1'b1;
        state_d  = ST_V_READ;
      end
      ST_P_FETCH: if (src_valid) begin
        ld_src  = 1'b1;
        state_d = ST_P_SETUP;
      end
      ST_P_SETUP: if (hit) state_d = ST_P_PULSE;
      ST_P_PULSE: if (hit) state_d = ST_P_HOLD;
      ST_P_HOLD:  if (hit) begin
        if (last) state_d = ST_P_REC;
        else begin
          addr_inc = 1'b1;
          state_d  = ST_P_FETCH;
        end
      end
      ST_P_REC: if (hit) begin
        addr_clr = 1'b1;
        state_d  = ST_V_FETCH;
      end
      ST_V_FETCH: if (src_valid) begin
        ld_src  = 1'b1;
        state_d = ST_V_READ;
      end
      ST_V_READ: if (hit) begin
        ld_rd   = 1'b1;
        state_d = ST_V_CMP;
      end
      ST_V_CMP: begin
        if (rd_q != expect_b) begin
          fin     = 1'b1;
          state_d = ST_DONE;
        end else if (last) begin
          if (!vfy_prog_q && prog_after_q) begin
            addr_clr = 1'b1;
            state_d  = ST_P_FETCH;
          end else begin
            fin     = 1'b1;
            fin_ok  = 1'b1;
            state_d = ST_DONE;
          end
        end else begin
          addr_inc = 1'b1;
          state_d  = vfy_prog_q ? ST_V_FETCH : ST_V_READ;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      prog_after_q <= 1'b0;
      vfy_prog_q   <= 1'b0;
      data_q       <= '0;
      rd_q         <= '0;
      pass_q       <= 1'b0;
      fail_addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d != ST_IDLE) begin
        prog_after_q <= mode[1];
        vfy_prog_q   <= !mode[0];
      end
      if (state_q == ST_V_CMP && state_d == ST_P_FETCH) vfy_prog_q <= 1'b1;
      if (ld_src) data_q <= src_data;
      if (ld_rd)  rd_q   <= dev_rdata;
      if (fin) begin
        pass_q      <= fin_ok;
        fail_addr_q <= fin_ok ? '0 : addr;
      end
    end
  end

  // pin levels decoded from the state
  always_comb begin
    hv_a9        = state_q inside {ST_E_ARM, ST_E_PULSE, ST_E_REL};
    hv_oe        = hv_a9 || (state_q inside {ST_P_FETCH, ST_P_SETUP, ST_P_PULSE, ST_P_HOLD});
    dev_ce_n     = !(hv_oe || state_q == ST_V_READ);
    dev_oe_n     = !(state_q inside {ST_V_READ, ST_P_REC});
    dev_we_n     = !(state_q inside {ST_E_PULSE, ST_P_PULSE});
    dev_wdata_oe = state_q inside {ST_P_SETUP, ST_P_PULSE, ST_P_HOLD};
    src_ready    = state_q inside {ST_P_FETCH, ST_V_FETCH};
  end

  assign src_addr  = addr;
  assign dev_addr  = addr;
  assign dev_wdata = data_q;
  assign busy      = state_q != ST_IDLE;
  assign done      = state_q == ST_DONE;
  assign pass      = pass_q;
  assign fail_addr = fail_addr_q;
endmodule

// File: rtl/prom_burn_seq_chk.sv
module prom_burn_seq_chk #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ERASE_CYC = 20_000_000,
  parameter int PROG_CYC  = 4000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] src_addr,
  input logic          src_ready,
  input logic          src_valid,
  input logic [AW-1:0] dev_addr,
  input logic [DW-1:0] dev_wdata,
  input logic          dev_ce_n,
  input logic          dev_oe_n,
  input logic          dev_we_n,
  input logic          hv_oe,
  input logic          hv_a9
);
  int lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || dev_we_n) lo_cnt <= 0;
    else                    lo_cnt <= lo_cnt + 1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dev_we_n && dev_ce_n && !hv_oe && !hv_a9 && !src_ready && !done);

  a_r3_erase_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_we_n && hv_a9) |-> hv_oe && !dev_ce_n);

  a_r6_prog_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_we_n && !hv_a9) |-> hv_oe && !dev_ce_n);

  // R3 and R6: low width counted on the cycle the strobe returns high
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_we_n) |-> lo_cnt == (hv_a9 ? ERASE_CYC : PROG_CYC));

  a_r4_no_read_hv: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_ce_n && !dev_oe_n) |-> !hv_oe && !hv_a9);

  a_r7_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_we_n) |-> $stable(dev_addr) && $stable(dev_wdata));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_we_n || $rose(dev_we_n)) |-> $stable(dev_addr) && $stable(dev_wdata));

  a_r11_src_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !src_valid) |=> src_ready && $stable(src_addr));

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

bind prom_burn_seq prom_burn_seq_chk #(
  .AW(AW), .DW(DW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .src_addr(src_addr), .src_ready(src_ready), .src_valid(src_valid),
  .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_ce_n(dev_ce_n),
  .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n), .hv_oe(hv_oe), .hv_a9(hv_a9)
);

// File: tb/prom_burn_seq_test.sv
`timescale 1ns/1ps
module prom_burn_seq_test;
  localparam int AW = 4, DW = 8;
  localparam int SETUP = 2, ERASE = 40, PROG = 6, REC = 10, RDW = 3;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic busy, done, pass, src_ready, dev_wdata_oe, dev_ce_n, dev_oe_n, dev_we_n, hv_oe, hv_a9;
  logic [AW-1:0] fail_addr, src_addr, dev_addr;
  logic [DW-1:0] src_data, dev_wdata, dev_rdata;
  logic src_valid = 1'b0;

  int checks = 0, fails = 0, cur_sel = 0;
  bit finished = 0;
  bit weak_en = 0;
  logic [AW-1:0] weak_addr = '0;
  logic [DW-1:0] weak_mask = '0;

  logic [DW-1:0] mem [NADDR];
  logic [AW+DW-1:0] sb_q [$];
  int prog_cnt = 0, erase_cnt = 0, rd_cnt = 0, lo = 0, gap = 0;
  logic [AW-1:0] rd_last = '0, rd_next = '0, prev_src_addr = '0;
  bit prev_we = 1, prev_rd = 0, since_pulse = 0, prev_stall = 0;
  logic [1:0] stall = '0;

  always #2.5 clk = ~clk;

  prom_burn_seq #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .ERASE_CYC(ERASE),
    .PROG_CYC(PROG), .REC_CYC(REC), .RD_WAIT(RDW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .done(done),
    .pass(pass), .fail_addr(fail_addr), .src_addr(src_addr), .src_ready(src_ready),
    .src_valid(src_valid), .src_data(src_data), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_wdata_oe(dev_wdata_oe), .dev_rdata(dev_rdata), .dev_ce_n(dev_ce_n),
    .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n), .hv_oe(hv_oe), .hv_a9(hv_a9));

  function automatic logic [DW-1:0] pat(input int sel, input logic [AW-1:0] a);
    logic [DW-1:0] b;
    b = DW'(a) * 8'd37 + 8'd5;
    case (sel)
      1:       return (DW'(a) * 8'd11) ^ 8'h5A;
      2:       return (a == 4'd11) ? (b | 8'h01) : b;
      default: return b;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  assign src_data  = pat(cur_sel, src_addr);
  assign dev_rdata = (!dev_ce_n && !dev_oe_n) ? mem[dev_addr] : 8'h00;

  // source with periodic stalls
  always @(negedge clk) begin
    stall = stall + 2'd1;
    src_valid = src_ready && (stall != 2'd0);
  end

  // ROM model and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NADDR; a++) mem[a] = '0;
      prev_we = 1;
    end else begin
      if (prev_we && !dev_we_n) begin
        lo = 0;
        rd_next = '0;
        if (hv_a9) begin
          erase_cnt++;
          for (int a = 0; a < NADDR; a++)
            mem[a] = (weak_en && AW'(a) == weak_addr) ? ~weak_mask : 8'hFF;
        end else begin
          prog_cnt++;
          if (sb_q.size() == 0) chk("R6 unexpected program pulse", 1, 0);
          else begin
            logic [AW+DW-1:0] e;
            e = sb_q.pop_front();
            chk("R6 write address order", 32'(dev_addr), 32'(e[AW+DW-1:DW]));
            chk("R6 write byte", 32'(dev_wdata), 32'(e[DW-1:0]));
          end
          mem[dev_addr] = mem[dev_addr] & dev_wdata;
        end
      end
      if (!dev_we_n) lo++;
      if (!prev_we && dev_we_n) begin
        chk(hv_a9 ? "R3 erase pulse width" : "R6 program pulse width", lo, hv_a9 ? ERASE : PROG);
        gap = 1;
        since_pulse = 1;
      end else if (dev_we_n && since_pulse && !(!dev_ce_n && !dev_oe_n)) gap++;
      if (!prev_rd && !dev_ce_n && !dev_oe_n) begin
        if (since_pulse) begin
          chk("R4/R8 recovery before first read", 32'(gap >= SETUP + REC), 1);
          since_pulse = 0;
        end
        chk("R5/R8 read address order", 32'(dev_addr), 32'(rd_next));
        rd_next = dev_addr + 1'b1;
        rd_last = dev_addr;
        rd_cnt++;
      end
      if (prev_stall && src_ready) chk("R11 address held under stall", 32'(src_addr), 32'(prev_src_addr));
      prev_stall    = src_ready && !src_valid;
      prev_src_addr = src_addr;
      prev_rd = !dev_ce_n && !dev_oe_n;
      prev_we = dev_we_n;
    end
  end

  task automatic push_prog(input int sel);
    for (int a = 0; a < NADDR; a++) sb_q.push_back({AW'(a), pat(sel, AW'(a))});
  endtask

  task automatic run(input logic [1:0] m, input bit poke, input bit exp_pass,
                     input logic [AW-1:0] exp_fa, input int exp_reads, input string tag);
    int p0, e0, r0;
    p0 = prog_cnt; e0 = erase_cnt; r0 = rd_cnt;
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0;
    chk({tag, " R10 busy after start"}, 32'(busy), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; mode = 2'b10;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk({tag, " R9/R10 pass"}, 32'(pass), 32'(exp_pass));
    chk({tag, " R9 fail_addr"}, 32'(fail_addr), 32'(exp_fa));
    chk({tag, " R5/R9 verify reads"}, rd_cnt - r0, exp_reads);
    if (!exp_pass) chk({tag, " R9 last read is fail address"}, 32'(rd_last), 32'(exp_fa));
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, 32'(done), 0);
    chk({tag, " R10 busy cleared"}, 32'(busy), 0);
    chk({tag, " R10 result held"}, 32'({pass, fail_addr}), 32'({exp_pass, exp_fa}));
    chk({tag, " R6 scoreboard drained"}, sb_q.size(), 0);
    chk({tag, " R3 erase pulses"}, erase_cnt - e0, m[0] ? 1 : 0);
    $display("%s: %0d program pulses", tag, prog_cnt - p0);
  endtask

  initial begin
    int exp_fa;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 strobes in reset", 32'({dev_we_n, dev_ce_n, dev_oe_n}), 3'b111);
    chk("R1 high voltage off in reset", 32'({hv_oe, hv_a9, src_ready, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'({busy, dev_we_n, hv_oe, hv_a9}), 32'b0100);

    // mode 00 starts nothing
    start = 1'b1; mode = 2'b00;
    @(negedge clk); start = 1'b0;
    chk("R2 mode 00 ignored", 32'(busy), 0);

    // erase from all-zero array, with a start poke during the run
    run(2'b01, 1, 1, '0, NADDR, "erase");
    repeat (3) @(negedge clk);
    chk("R2 start during run ignored", 32'(busy), 0);
    for (int a = 0; a < NADDR; a++) chk("R5 array blank", 32'(mem[a]), 8'hFF);

    // program with stalling source
    cur_sel = 0; push_prog(0);
    run(2'b10, 0, 1, '0, NADDR, "program");
    for (int a = 0; a < NADDR; a++) chk("R6/R11 array contents", 32'(mem[a]), 32'(pat(0, AW'(a))));

    // reprogram without erase: only zero bits may be cleared
    exp_fa = -1;
    for (int a = NADDR - 1; a >= 0; a--)
      if ((pat(0, AW'(a)) & pat(2, AW'(a))) != pat(2, AW'(a))) exp_fa = a;
    cur_sel = 2; push_prog(2);
    run(2'b10, 0, 0, AW'(exp_fa), exp_fa + 1, "reprogram");

    // erase then program
    cur_sel = 1; push_prog(1);
    run(2'b11, 0, 1, '0, 2 * NADDR, "erase+program");
    for (int a = 0; a < NADDR; a++) chk("R2/R8 array contents", 32'(mem[a]), 32'(pat(1, AW'(a))));

    // erase leaves a weak bit: program must be skipped
    weak_en = 1; weak_addr = 4'd9; weak_mask = 8'h10;
    run(2'b11, 0, 0, 4'd9, 10, "weak erase");
    chk("R12 no program after failed erase", 32'(mem[0]), 8'hFF);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule